// File: doc/BRIEF.md
# Bus-Clamped Space-Vector PWM Sequencer

This block drives the three pole gate signals (phases R, Y, B) of a two-level voltage-source inverter for one PWM subcycle at a time. Each subcycle begins with a start pulse. At that edge the block captures the sector of the reference vector (1 to 6), a flag for the first or second half of that sector, the dwell times of the two active states, the total zero-state time, a clamping-type select and a conventional-mode select. It then steps through the chosen switching sequence. It holds each state for its dwell, counted in clock ticks, and marks the final cycle of the subcycle with a one-cycle done pulse.

In clamping mode the subcycle uses only one zero state. This keeps one phase tied to a DC rail for the whole subcycle, so only two phases switch. The zero state is chosen from the clamping type, the sector and, for two of the types, the half-sector flag. In conventional mode both zero states are used and every phase switches once. The sequence runs from the all-negative end toward the all-positive end in one subcycle and in the opposite order in the next. This way the state at the boundary between subcycles is shared. Dwell computation, dead-time insertion and angle tracking are handled elsewhere.

The parameter `MID_SECTOR_EN` can be cleared to drop the half-sector dependent types. When it is cleared, those two type codes fall back to the sector-parity rules.

Top module: `svpwm_clamp_seq`

## Requirements
- R1: After reset the poles are 000 (R,Y,B) and done is 0, and they stay there until the first start.
- R2: States map to poles (R,Y,B, 1 = positive rail) as follows: 0=000, 1=100, 2=110, 3=010, 4=011, 5=001, 6=101, 7=111. Sector k uses active states k and k+1, with sector 6 using states 6 and 1. The first dwell input belongs to state k and the second to the other state. The active state with one positive pole sits next to state 0 in the sequence.
- R3: In conventional mode the forward order is 0, single-positive active, double-positive active, 7. State 0 gets floor(TZ/2) cycles and state 7 gets the remaining TZ-floor(TZ/2) cycles.
- R4: In clamping mode a subcycle contains exactly one zero state, and that state receives the full TZ. The forward order is 0, single-positive active, double-positive active when state 0 is used, and single-positive active, double-positive active, 7 when state 7 is used. The unused zero state never appears.
- R5: Clamp-type code 2 uses state 7 in odd sectors and state 0 in even sectors. Code 1 is the reverse of code 2. For both codes the half-sector flag has no effect.
- R6: Clamp-type code 0 uses state 7 in the first half (flag 0) of odd sectors and in the second half (flag 1) of even sectors, and state 0 otherwise. Code 3 is the complement of code 0.
- R7: The first subcycle after reset runs forward. Each accepted start toggles the direction, and a reverse subcycle plays the forward list in reverse order.
- R8: A subcycle lasts T1+T2+TZ cycles, counted from the edge that accepts start. done is high on exactly its last cycle.
- R9: A start that arrives while a subcycle is running and not in its last cycle is ignored. Input changes during a subcycle have no effect on it, and the ignored start does not toggle the direction.
- R10: A state whose dwell is zero is skipped, and the poles go directly to the next state.
- R11: With no new start, the poles hold the final state of the last subcycle and done stays 0.
- R12: A start during the done cycle begins the next subcycle at the following edge with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Subcycle start request |
| sector_i | input | 3 | Sector number 1..6 |
| half_i | input | 1 | 0 = first half of sector, 1 = second half |
| t1_i | input | TW | Dwell of active state k, in clock ticks |
| t2_i | input | TW | Dwell of active state k+1, in clock ticks |
| tz_i | input | TW | Total zero-state time, in clock ticks |
| clamp_type_i | input | 2 | Clamp-type code 0..3 |
| conv_mode_i | input | 1 | 1 = conventional sequence using both zero states |
| pole_r_o | output | 1 | Phase R pole, 1 = positive rail |
| pole_y_o | output | 1 | Phase Y pole, 1 = positive rail |
| pole_b_o | output | 1 | Phase B pole, 1 = positive rail |
| done_o | output | 1 | High in the last cycle of a subcycle |

## Verification
A stale direction register appears on the first pole value after the next start: that subcycle opens with the wrong end state, one cycle after the accepting edge. A wrong zero-state choice shows as a wrong clamped rail, which is visible in the first or last segment of the affected subcycle. Corrupted segment boundaries move the pole edges by a cycle or more and also move the done pulse. Because of this, every expected pole value is compared on every cycle, including idle holds and subcycles that follow each other with no gap.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

   typedef enum logic [1:0] {
      CLAMP_MID_P = 2'd0,
      CLAMP_EDGE_N = 2'd1,
      CLAMP_EDGE_P = 2'd2,
      CLAMP_MID_N = 2'd3
   } clamp_type_e;

   localparam int NSEG = 4;

   // Pole pattern R,Y,B for a space-vector state number
   function automatic logic [2:0] state_poles(input logic [2:0] st);
      logic [2:0] p;
      unique case (st)
         3'd1: p = 3'b100;
         3'd2: p = 3'b110;
         3'd3: p = 3'b010;
         3'd4: p = 3'b011;
         3'd5: p = 3'b001;
         3'd6: p = 3'b101;
         3'd7: p = 3'b111;
         default: p = 3'b000;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/svpwm_zero_sel.sv
module svpwm_zero_sel #(
   parameter bit MID_SECTOR_EN = 1'b1
) (
   input  logic [2:0] sector_i,
   input  logic       half_i,
   input  logic [1:0] ctype_i,
   output logic       use7_o
);
   import svpwm_pkg::*;

   logic odd_sec;
   assign odd_sec = sector_i[0];

   generate
      if (MID_SECTOR_EN) begin : g_mid
         always_comb begin
            unique case (ctype_i)
               CLAMP_MID_P:  use7_o = odd_sec ^ half_i;
               CLAMP_MID_N:  use7_o = ~(odd_sec ^ half_i);
               CLAMP_EDGE_P: use7_o = odd_sec;
               default:      use7_o = ~odd_sec;
            endcase
         end
      end else begin : g_edge_only
         always_comb begin
            unique case (ctype_i)
               CLAMP_MID_P, CLAMP_EDGE_P: use7_o = odd_sec;
               default:                   use7_o = ~odd_sec;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/svpwm_seg_build.sv
module svpwm_seg_build #(
   parameter int TW = 12
) (
   input  logic [2:0]             sector_i,
   input  logic                   dir_rev_i,
   input  logic                   conv_i,
   input  logic                   use7_i,
   input  logic [TW-1:0]          t1_i,
   input  logic [TW-1:0]          t2_i,
   input  logic [TW-1:0]          tz_i,
   output logic [3:0][2:0]        seg_st_o,
   output logic [3:0][TW-1:0]     seg_dw_o
);

   logic [2:0]    sec_n;
   logic [2:0]    sec_next;
   logic [2:0]    lo_st;
   logic [2:0]    hi_st;
   logic [TW-1:0] lo_dw;
   logic [TW-1:0] hi_dw;
   logic [TW-1:0] z0_dw;
   logic [TW-1:0] z7_dw;

   // Out-of-range sector codes fall back to sector 1
   assign sec_n    = (sector_i == 3'd0 || sector_i == 3'd7) ? 3'd1 : sector_i;
   assign sec_next = (sec_n == 3'd6) ? 3'd1 : sec_n + 3'd1;

   // Odd state numbers have a single positive pole and sit next to state 0
   always_comb begin
      if (sec_n[0]) begin
         lo_st = sec_n;    lo_dw = t1_i;
         hi_st = sec_next; hi_dw = t2_i;
      end else begin
         hi_st = sec_n;    hi_dw = t1_i;
         lo_st = sec_next; lo_dw = t2_i;
      end
   end

   assign z0_dw = tz_i >> 1;
   assign z7_dw = tz_i - z0_dw;

   always_comb begin
      seg_st_o = '0;
      seg_dw_o = '0;
      if (conv_i) begin
         if (!dir_rev_i) begin
            seg_st_o = {3'd7, hi_st, lo_st, 3'd0};
            seg_dw_o = {z7_dw, hi_dw, lo_dw, z0_dw};
         end else begin
            seg_st_o = {3'd0, lo_st, hi_st, 3'd7};
            seg_dw_o = {z0_dw, lo_dw, hi_dw, z7_dw};
         end
      end else if (use7_i) begin
         if (!dir_rev_i) begin
            seg_st_o = {3'd7, 3'd7, hi_st, lo_st};
            seg_dw_o = {{TW{1'b0}}, tz_i, hi_dw, lo_dw};
         end else begin
            seg_st_o = {lo_st, lo_st, hi_st, 3'd7};
            seg_dw_o = {{TW{1'b0}}, lo_dw, hi_dw, tz_i};
         end
      end else begin
         if (!dir_rev_i) begin
            seg_st_o = {hi_st, hi_st, lo_st, 3'd0};
            seg_dw_o = {{TW{1'b0}}, hi_dw, lo_dw, tz_i};
         end else begin
            seg_st_o = {3'd0, 3'd0, lo_st, hi_st};
            seg_dw_o = {{TW{1'b0}}, tz_i, lo_dw, hi_dw};
         end
      end
   end

endmodule

// File: rtl/svpwm_seg_timer.sv
module svpwm_seg_timer #(
   parameter int TW = 12,
   parameter int NSEG = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [NSEG-1:0][2:0]    seg_st_i,
   input  logic [NSEG-1:0][TW-1:0] seg_dw_i,
   output logic [2:0]              cur_st_o,
   output logic                    busy_o,
   output logic                    last_o
);
   localparam int CW = TW + $clog2(NSEG) + 1;

   logic [NSEG-1:0][2:0]    st_q;
   logic [NSEG-1:0][CW-1:0] bnd_q;
   logic [NSEG-1:0][CW-1:0] bnd_d;
   logic [CW-1:0]           cnt_q;
   logic                    busy_q;
   logic [CW:0]             cnt_nxt;

   // Running end-of-segment boundaries
   always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int i = 0; i < NSEG; i++) begin
         acc      = acc + CW'(seg_dw_i[i]);
         bnd_d[i] = acc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '0;
         bnd_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         st_q   <= seg_st_i;
         bnd_q  <= bnd_d;
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (last_o) busy_q <= 1'b0;
         else        cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
   assign last_o  = busy_q && (cnt_nxt >= {1'b0, bnd_q[NSEG-1]});
   assign busy_o  = busy_q;

   // First segment whose boundary lies beyond the count
   always_comb begin
      cur_st_o = st_q[NSEG-1];
      for (int i = NSEG - 2; i >= 0; i--) begin
         if (cnt_q < bnd_q[i]) cur_st_o = st_q[i];
      end
   end

   AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !load_i |=> !busy_q);  // R8
   AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && bnd_q[NSEG-1] != '0 |-> cnt_q < bnd_q[NSEG-1]);  // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && !load_i |=> $stable(cur_st_o) && !last_o);  // R11

endmodule

// File: rtl/svpwm_clamp_seq.sv
module svpwm_clamp_seq #(
   parameter int TW = 12,
   parameter bit MID_SECTOR_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    sector_i,
   input  logic          half_i,
   input  logic [TW-1:0] t1_i,
   input  logic [TW-1:0] t2_i,
   input  logic [TW-1:0] tz_i,
   input  logic [1:0]    clamp_type_i,
   input  logic          conv_mode_i,
   output logic          pole_r_o,
   output logic          pole_y_o,
   output logic          pole_b_o,
   output logic          done_o
);
   import svpwm_pkg::*;

   generate
      if (TW < 2 || TW > 24) begin : g_bad_tw
         $error("svpwm_clamp_seq: TW out of supported range");
      end
   endgenerate

   logic                 busy;
   logic                 last;
   logic                 accept;
   logic                 dir_q;
   logic                 use7;
   logic                 use7_q;
   logic                 conv_q;
   logic [NSEG-1:0][2:0]    seg_st;
   logic [NSEG-1:0][TW-1:0] seg_dw;
   logic [2:0]           cur_st;

   assign accept = start_i && (!busy || last);

   svpwm_zero_sel #(.MID_SECTOR_EN(MID_SECTOR_EN)) u_zsel (
      .sector_i (sector_i),
      .half_i   (half_i),
      .ctype_i  (clamp_type_i),
      .use7_o   (use7)
   );

   svpwm_seg_build #(.TW(TW)) u_build (
      .sector_i  (sector_i),
      .dir_rev_i (dir_q),
      .conv_i    (conv_mode_i),
      .use7_i    (use7),
      .t1_i      (t1_i),
      .t2_i      (t2_i),
      .tz_i      (tz_i),
      .seg_st_o  (seg_st),
      .seg_dw_o  (seg_dw)
   );

   svpwm_seg_timer #(.TW(TW), .NSEG(NSEG)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .seg_st_i (seg_st),
      .seg_dw_i (seg_dw),
      .cur_st_o (cur_st),
      .busy_o   (busy),
      .last_o   (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= 1'b0;
         use7_q <= 1'b0;
         conv_q <= 1'b0;
      end else if (accept) begin
         dir_q  <= ~dir_q;
         use7_q <= use7;
         conv_q <= conv_mode_i;
      end
   end

   assign {pole_r_o, pole_y_o, pole_b_o} = state_poles(cur_st);
   assign done_o = last;

   AST_UNUSED_ZERO_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !conv_q |-> cur_st != (use7_q ? 3'd0 : 3'd7));  // R4
   AST_MIDRUN_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && busy && !last |=> $stable(dir_q));  // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !done_o);  // R8

endmodule

// File: tb/svpwm_clamp_seq_bench.sv
module svpwm_clamp_seq_bench;
   localparam int TW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    sector_i = 3'd1;
   logic          half_i = 1'b0;
   logic [TW-1:0] t1_i = '0, t2_i = '0, tz_i = '0;
   logic [1:0]    clamp_type_i = 2'd0;
   logic          conv_mode_i = 1'b0;
   logic          pole_r_o, pole_y_o, pole_b_o, done_o;

   always #4 clk = ~clk;

   svpwm_clamp_seq #(.TW(TW)) u_svpwm_clamp_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
      .half_i(half_i), .t1_i(t1_i), .t2_i(t2_i), .tz_i(tz_i),
      .clamp_type_i(clamp_type_i), .conv_mode_i(conv_mode_i),
      .pole_r_o(pole_r_o), .pole_y_o(pole_y_o), .pole_b_o(pole_b_o),
      .done_o(done_o)
   );

   logic [3:0] exp_q[$];
   string      req_q[$];
   int         n_chk = 0;
   int         n_fail = 0;
   bit         dir_m = 1'b0;
   logic [2:0] last_p = 3'b000;

   function automatic logic [2:0] pv(input int s);
      case (s)
         1: return 3'b100; 2: return 3'b110; 3: return 3'b010;
         4: return 3'b011; 5: return 3'b001; 6: return 3'b101;
         7: return 3'b111; default: return 3'b000;
      endcase
   endfunction

   // Monitor: pops one expected item per cycle, compared away from the edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [3:0] e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         n_chk++;
         if ({pole_r_o, pole_y_o, pole_b_o, done_o} !== e) begin
            n_fail++;
            $display("FAIL %s: poles=%b done=%b expected poles=%b done=%b",
                     r, {pole_r_o, pole_y_o, pole_b_o}, done_o, e[3:1], e[0]);
         end
      end
   end

   // Driver: starts a subcycle and pushes its cycle-by-cycle expectation
   task automatic run(input int sec, input bit half, input int t1, input int t2,
                      input int tz, input int ty, input bit conv, input string r,
                      input bit poke);
      int st[4];
      int dw[4];
      int n, lo, hi, ldw, hdw, nx, total, k;
      bit odd, use7;
      nx  = (sec == 6) ? 1 : sec + 1;
      odd = sec[0];
      if (odd) begin lo = sec; ldw = t1; hi = nx; hdw = t2; end
      else     begin hi = sec; hdw = t1; lo = nx; ldw = t2; end
      case (ty)
         0: use7 = odd ^ half;
         3: use7 = !(odd ^ half);
         2: use7 = odd;
         default: use7 = !odd;
      endcase
      n = 0;
      if (conv) begin
         st[0] = 0; dw[0] = tz / 2; st[1] = lo; dw[1] = ldw;
         st[2] = hi; dw[2] = hdw; st[3] = 7; dw[3] = tz - tz / 2; n = 4;
      end else if (use7) begin
         st[0] = lo; dw[0] = ldw; st[1] = hi; dw[1] = hdw; st[2] = 7; dw[2] = tz; n = 3;
      end else begin
         st[0] = 0; dw[0] = tz; st[1] = lo; dw[1] = ldw; st[2] = hi; dw[2] = hdw; n = 3;
      end
      total = t1 + t2 + tz;
      sector_i = 3'(sec); half_i = half; t1_i = TW'(t1); t2_i = TW'(t2);
      tz_i = TW'(tz); clamp_type_i = 2'(ty); conv_mode_i = conv; start_i = 1'b1;
      @(posedge clk);
      #1 start_i = 1'b0;
      k = 0;
      for (int j = 0; j < n; j++) begin
         int idx;
         idx = dir_m ? n - 1 - j : j;
         for (int c = 0; c < dw[idx]; c++) begin
            k++;
            exp_q.push_back({pv(st[idx]), k == total});
            req_q.push_back(r);
            last_p = pv(st[idx]);
         end
      end
      dir_m = !dir_m;
      if (poke) begin
         // R9: changed inputs plus a start while running must be ignored
         @(negedge clk);
         sector_i = 3'd4; t1_i = TW'(9); tz_i = TW'(1); conv_mode_i = !conv;
         clamp_type_i = 2'(ty + 1); start_i = 1'b1;
         @(posedge clk);
         #1 start_i = 1'b0;
      end
      wait (exp_q.size() == 0);
   endtask

   task automatic idle(input int n, input string r);
      start_i = 1'b0;
      @(posedge clk);
      #1;
      for (int i = 0; i < n; i++) begin
         exp_q.push_back({last_p, 1'b0});
         req_q.push_back(r);
      end
      wait (exp_q.size() == 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state held before release
      n_chk++;
      if ({pole_r_o, pole_y_o, pole_b_o, done_o} !== 4'b0000) begin
         n_fail++;
         $display("FAIL R1: poles/done=%b expected 0000",
                  {pole_r_o, pole_y_o, pole_b_o, done_o});
      end
      rst_n = 1'b1;
      @(negedge clk);
      idle(3, "R1");
      // R3 forward then R7 reverse, back to back (R12)
      run(1, 0, 3, 2, 5, 0, 1, "R3", 0);
      run(1, 0, 3, 2, 5, 0, 1, "R7", 0);
      run(2, 1, 2, 4, 3, 1, 1, "R12", 0);
      // R2: conventional sweep over all sectors
      for (int s = 1; s <= 6; s++) run(s, 0, 1 + s % 3, 2, 4, 0, 1, "R2", 0);
      idle(4, "R11");
      // R4/R5/R6: clamp sweep over types, sectors and halves
      for (int ty = 0; ty < 4; ty++)
         for (int s = 1; s <= 6; s++)
            for (int h = 0; h < 2; h++)
               run(s, h[0], 1 + s % 3, 2, 3, ty, 0,
                   (ty == 1 || ty == 2) ? "R5" : "R6", 0);
      run(3, 0, 2, 2, 4, 2, 0, "R4", 0);
      // R10: zero dwell segments skipped
      run(1, 0, 0, 3, 2, 0, 1, "R10", 0);
      run(5, 1, 2, 0, 3, 3, 0, "R10", 0);
      run(4, 0, 3, 2, 0, 1, 0, "R10", 0);
      // R9: mid-run start ignored, direction continues unchanged
      run(6, 0, 3, 3, 4, 2, 0, "R9", 1);
      run(6, 0, 3, 3, 4, 2, 0, "R9", 0);
      idle(5, "R11");
      // R8: single-cycle subcycles and length check
      run(2, 0, 1, 0, 0, 2, 0, "R8", 0);
      run(2, 0, 0, 0, 1, 1, 0, "R8", 0);
      run(5, 1, 4, 5, 6, 0, 1, "R8", 0);
      idle(3, "R11");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule